// File: doc/BRIEF.md
# Floating-Point Compare and Exception Status Unit

This block owns a floating-point status word. It updates the word from two sources. The first is the five IEEE exception flags that an external arithmetic unit reports. The second is the result of a single-precision compare of two 32-bit operands, which the block works out itself. Each update takes one clock edge. When an exception is both raised and enabled, the block marks the trap-type field and sends a one-cycle trap pulse. When a raised exception is not enabled, it is folded into the accrued field instead. The block also decodes the rounding-mode field into a one-hot mode vector for the datapath.

Software-visible state enters only through a whole-word load strobe. A small two-state machine produces the trap pulse. In `ST_IDLE` the trap output is low. The transition `GO_TRAP` is taken on any accepted event that raises a trap, and it enters `ST_TRAP`, where the output is high for exactly one cycle. From `ST_TRAP`, the transition `RETRAP` stays in `ST_TRAP` if the next accepted event also traps, and `CLEAR` returns to `ST_IDLE` otherwise.

Status word layout (38 bits), used by every requirement below:

- current exceptions: bits [4:0], with invalid at bit 4, overflow at 3, underflow at 2, divide-by-zero at 1 and inexact at 0
- accrued exceptions: bits [9:5], in the same order
- condition fields: field 0 at [11:10], field 1 at [33:32], field 2 at [35:34], field 3 at [37:36]
- trap type: bits [16:14]
- trap enables: bits [27:23], in the same flag order
- rounding mode: bits [31:30]

Top module: `fp_status_unit`

## Requirements
- R1: While synchronous reset is high, and after it is released, the status word reads all zeros, trap_o is 0 and round_o is 4'b0001.
- R2: A load strobe writes ld_data_i into the whole status word at the next edge. It outranks the flag and compare strobes, which are ignored in that cycle.
- R3: An accepted flag strobe copies flags_i into the current-exception bits [4:0], in the order invalid 4, overflow 3, underflow 2, divide-by-zero 1, inexact 0.
- R4: If flags_i ANDed with the enables at bits [27:23] is nonzero, trap type [16:14] becomes 3'd1 and trap_o is high for the cycle after the edge. The accrued bits do not change.
- R5: If no raised flag is enabled, flags_i is ORed into accrued bits [9:5], trap type does not change and no trap is raised. Accrued bits never clear except by load or reset.
- R6: A compare writes its relation into the selected 2-bit condition field: equal 00, less 01, greater 10, unordered 11. Selector 0, 1, 2 and 3 maps to bits [11:10], [33:32], [35:34] and [37:36]. The other condition fields keep their values.
- R7: An operand with exponent 8'hFF and a nonzero fraction is a NaN and makes the result unordered. +0 and -0 compare equal. Infinities and denormals follow numeric order.
- R8: An unordered quiet compare with invalid enable bit 27 clear sets accrued-invalid bit 9. It leaves the current bits and trap type unchanged and raises no trap.
- R9: An unordered compare that is either signaling, or has bit 27 set, sets current-invalid bit 4 and trap type 3'd1, and raises a trap.
- R10: round_o decodes bits [31:30] one-hot: value 0 (nearest even) gives bit 0, 1 (toward zero) gives bit 1, 2 (up) gives bit 2, and 3 (down) gives bit 3.
- R11: When flag and compare strobes arrive together, the flag strobe is applied and the compare is ignored.
- R12: trap_o is high only in the cycle directly after an accepted event that trapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ld_valid_i | input | 1 | Load whole status word |
| ld_data_i | input | 38 | Status word value to load |
| flag_valid_i | input | 1 | IEEE flags from arithmetic unit are valid |
| flags_i | input | 5 | IEEE flags: invalid, overflow, underflow, divide-by-zero, inexact |
| cmp_valid_i | input | 1 | Compare request |
| cmp_signal_i | input | 1 | Signaling compare (unordered always traps) |
| cmp_sel_i | input | 2 | Condition field selector |
| op_a_i | input | 32 | First single-precision operand |
| op_b_i | input | 32 | Second single-precision operand |
| status_o | output | 38 | Status word |
| trap_o | output | 1 | One-cycle trap pulse |
| round_o | output | 4 | One-hot rounding mode |

## Verification
An event strobed before clock edge k shows in status_o immediately after edge k, and trap_o is high during the cycle that follows edge k. round_o tracks the status word combinationally, so it is due in the same cycle as the loaded value. The bench drives every strobe on a falling edge and removes it on the next falling edge, and it samples status_o, trap_o and round_o at that second falling edge. It then samples trap_o once more a full cycle later to confirm that the pulse has ended.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
    localparam int FLAG_W    = 5;
    localparam int CEXC_LO   = 0;
    localparam int AEXC_LO   = CEXC_LO + FLAG_W;
    localparam int FCC0_LO   = 10;
    localparam int FTT_LO    = 14;
    localparam int FTT_W     = 3;
    localparam int TEM_LO    = 23;
    localparam int RND_LO    = 30;
    localparam int FCC_NUM   = 4;
    localparam int FCC_BASE  = 20;
    localparam int STAT_W    = FCC0_LO + FCC_BASE + 2 * (FCC_NUM - 1) + 2;
    localparam int NV_BIT    = 4;
    localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

    typedef enum logic [1:0] {
        REL_EQ = 2'b00,
        REL_LT = 2'b01,
        REL_GT = 2'b10,
        REL_UN = 2'b11
    } rel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } trap_state_e;

    function automatic logic [5:0] fcc_lo(input logic [1:0] sel);
        if (sel == 2'd0) return 6'(FCC0_LO);
        return 6'(FCC0_LO + FCC_BASE + 2 * int'(sel));
    endfunction

    function automatic logic [1:0] get_fcc(input logic [STAT_W-1:0] s, input logic [1:0] sel);
        return s[fcc_lo(sel) +: 2];
    endfunction
endpackage

// File: rtl/fpsu_fcmp.sv
module fpsu_fcmp
    import fpsu_pkg::*;
#(
    parameter int FP_W  = 32,
    parameter int EXP_W = 8
) (
    input  logic [FP_W-1:0] a_i,
    input  logic [FP_W-1:0] b_i,
    output rel_e            rel_o
);
    localparam int FRAC_W = FP_W - 1 - EXP_W;
    localparam int MAG_W  = FP_W - 1;

    logic [MAG_W-1:0] mag_a, mag_b;
    logic             sgn_a, sgn_b, nan_a, nan_b, zeros;

    assign sgn_a = a_i[FP_W-1];
    assign sgn_b = b_i[FP_W-1];
    assign mag_a = a_i[MAG_W-1:0];
    assign mag_b = b_i[MAG_W-1:0];
    assign nan_a = (&a_i[MAG_W-1 -: EXP_W]) && (|a_i[FRAC_W-1:0]);
    assign nan_b = (&b_i[MAG_W-1 -: EXP_W]) && (|b_i[FRAC_W-1:0]);
    assign zeros = (mag_a == '0) && (mag_b == '0);

    always_comb begin
        if (nan_a || nan_b)                 rel_o = REL_UN;
        else if (zeros || (a_i == b_i))     rel_o = REL_EQ;
        else if (sgn_a != sgn_b)            rel_o = sgn_a ? REL_LT : REL_GT;
        else if (!sgn_a)                    rel_o = (mag_a < mag_b) ? REL_LT : REL_GT;
        else                                rel_o = (mag_a > mag_b) ? REL_LT : REL_GT;
    end
endmodule

// File: rtl/fpsu_round_dec.sv
module fpsu_round_dec #(
    parameter int SEL_W = 2,
    localparam int MODES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] fld_i,
    output logic [MODES-1:0] mode_o
);
    for (genvar i = 0; i < MODES; i++) begin : g_mode
        assign mode_o[i] = (fld_i == SEL_W'(i));
    end
endmodule

// File: rtl/fpsu_ctrl.sv
module fpsu_ctrl
    import fpsu_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ld_valid_i,
    input  logic [STAT_W-1:0] ld_data_i,
    input  logic              flag_valid_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              cmp_valid_i,
    input  logic              cmp_signal_i,
    input  logic [1:0]        cmp_sel_i,
    input  rel_e              rel_i,
    output logic [STAT_W-1:0] status_o,
    output logic              trap_o
);
    logic [STAT_W-1:0] status_q, status_d;
    trap_state_e       state_q, state_d;
    logic              trap_evt;
    logic [5:0]        lo;
    logic              flg_acc, cmp_acc;

    assign flg_acc = flag_valid_i && !ld_valid_i;
    assign cmp_acc = cmp_valid_i && !ld_valid_i && !flag_valid_i;

    always_comb begin
        status_d = status_q;
        trap_evt = 1'b0;
        lo       = fcc_lo(cmp_sel_i);
        if (ld_valid_i) begin
            status_d = ld_data_i;
        end else if (flag_valid_i) begin
            status_d[CEXC_LO +: FLAG_W] = flags_i;
            if ((flags_i & status_q[TEM_LO +: FLAG_W]) != '0) begin
                status_d[FTT_LO +: FTT_W] = FTT_IEEE;
                trap_evt = 1'b1;
            end else begin
                status_d[AEXC_LO +: FLAG_W] = status_q[AEXC_LO +: FLAG_W] | flags_i;
            end
        end else if (cmp_valid_i) begin
            status_d[lo +: 2] = rel_i;
            if (rel_i == REL_UN) begin
                if (status_q[TEM_LO + NV_BIT] || cmp_signal_i) begin
                    status_d[CEXC_LO + NV_BIT] = 1'b1;
                    status_d[FTT_LO +: FTT_W]  = FTT_IEEE;
                    trap_evt = 1'b1;
                end else begin
                    status_d[AEXC_LO + NV_BIT] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) status_q <= '0;
        else       status_q <= status_d;
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // next state: GO_TRAP, RETRAP, CLEAR
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = trap_evt ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_d = trap_evt ? ST_TRAP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        trap_o   = (state_q == ST_TRAP);
        status_o = status_q;
    end

    AST_CEXC_COPY: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(flg_acc)) |-> (status_q[CEXC_LO +: FLAG_W] == $past(flags_i))); // R3
    AST_ACCRUED_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(ld_valid_i)) |->
        ((status_q[AEXC_LO +: FLAG_W] & $past(status_q[AEXC_LO +: FLAG_W])) == $past(status_q[AEXC_LO +: FLAG_W]))); // R5
    AST_TRAP_TYPE: assert property (@(posedge clk_i) disable iff (rst_i)
        trap_o |-> (status_q[FTT_LO +: FTT_W] == FTT_IEEE)); // R4
    AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && trap_o) |-> ($past(flg_acc) || $past(cmp_acc))); // R12
    AST_FIELD_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(cmp_acc)) |-> (get_fcc(status_q, $past(cmp_sel_i)) == $past(rel_i))); // R6
    AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(ld_valid_i)) |-> (status_q == $past(ld_data_i))); // R2
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
    import fpsu_pkg::*;
#(
    parameter int FP_W  = 32,
    parameter int EXP_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ld_valid_i,
    input  logic [STAT_W-1:0] ld_data_i,
    input  logic              flag_valid_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              cmp_valid_i,
    input  logic              cmp_signal_i,
    input  logic [1:0]        cmp_sel_i,
    input  logic [FP_W-1:0]   op_a_i,
    input  logic [FP_W-1:0]   op_b_i,
    output logic [STAT_W-1:0] status_o,
    output logic              trap_o,
    output logic [3:0]        round_o
);
    rel_e rel;

    fpsu_fcmp #(.FP_W(FP_W), .EXP_W(EXP_W)) i_fcmp (
        .a_i   (op_a_i),
        .b_i   (op_b_i),
        .rel_o (rel)
    );

    fpsu_ctrl i_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .ld_valid_i   (ld_valid_i),
        .ld_data_i    (ld_data_i),
        .flag_valid_i (flag_valid_i),
        .flags_i      (flags_i),
        .cmp_valid_i  (cmp_valid_i),
        .cmp_signal_i (cmp_signal_i),
        .cmp_sel_i    (cmp_sel_i),
        .rel_i        (rel),
        .status_o     (status_o),
        .trap_o       (trap_o)
    );

    fpsu_round_dec #(.SEL_W(2)) i_rdec (
        .fld_i  (status_o[RND_LO +: 2]),
        .mode_o (round_o)
    );

    AST_ROUND_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(round_o)); // R10
    AST_NAN_UNORDERED: assert property (@(posedge clk_i) disable iff (rst_i)
        ((&op_a_i[FP_W-2 -: EXP_W]) && (|op_a_i[FP_W-2-EXP_W:0])) |-> (rel == REL_UN)); // R7
endmodule

// File: tb/test_fp_status_unit.sv
module test_fp_status_unit;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 38;

    logic          clk = 1'b0;
    logic          rst;
    logic          ld_valid, flag_valid, cmp_valid, cmp_signal;
    logic [SW-1:0] ld_data;
    logic [4:0]    flags;
    logic [1:0]    cmp_sel;
    logic [31:0]   op_a, op_b;
    logic [SW-1:0] status;
    logic          trap;
    logic [3:0]    round;
    int            n_chk = 0;
    int            n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fp_status_unit i_fp_status_unit (
        .clk_i(clk), .rst_i(rst), .ld_valid_i(ld_valid), .ld_data_i(ld_data),
        .flag_valid_i(flag_valid), .flags_i(flags), .cmp_valid_i(cmp_valid),
        .cmp_signal_i(cmp_signal), .cmp_sel_i(cmp_sel), .op_a_i(op_a), .op_b_i(op_b),
        .status_o(status), .trap_o(trap), .round_o(round)
    );

    // {a, b, expected relation}
    localparam logic [65:0] VEC [12] = '{
        {32'h3F800000, 32'h40000000, 2'b01},
        {32'h40000000, 32'h3F800000, 2'b10},
        {32'h3F800000, 32'h3F800000, 2'b00},
        {32'h00000000, 32'h80000000, 2'b00},
        {32'hBF800000, 32'h3F800000, 2'b01},
        {32'hBF800000, 32'hC0000000, 2'b10},
        {32'h7F800000, 32'h3F800000, 2'b10},
        {32'hFF800000, 32'hBF800000, 2'b01},
        {32'h7FC00000, 32'h3F800000, 2'b11},
        {32'h3F800000, 32'h7F800001, 2'b11},
        {32'h80000000, 32'h3F800000, 2'b01},
        {32'h00000001, 32'h00000000, 2'b10}
    };

    function automatic int fld_pos(input logic [1:0] sel);
        case (sel)
            2'd0: return 10;
            2'd1: return 32;
            2'd2: return 34;
            default: return 36;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ld_valid = 0; ld_data = '0; flag_valid = 0; flags = '0;
        cmp_valid = 0; cmp_signal = 0; cmp_sel = '0; op_a = '0; op_b = '0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_load(input logic [SW-1:0] v);
        @(negedge clk);
        ld_valid = 1; ld_data = v;
        step();
    endtask

    task automatic do_flags(input logic [4:0] f);
        @(negedge clk);
        flag_valid = 1; flags = f;
        step();
    endtask

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input logic sig, input logic [1:0] sel);
        @(negedge clk);
        cmp_valid = 1; cmp_signal = sig; cmp_sel = sel; op_a = a; op_b = b;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [SW-1:0] exp;
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1", "status in reset", 64'(status), 64'h0);
        check("R1", "trap in reset", 64'(trap), 64'h0);
        rst = 0;
        @(negedge clk);
        check("R1", "status after reset", 64'(status), 64'h0);
        check("R1", "round after reset", 64'(round), 64'h1);

        // R10: round decode for each mode
        for (int m = 0; m < 4; m++) begin
            do_load(SW'(m) << 30);
            check("R10", "round one-hot", 64'(round), 64'(4'b1 << m));
            check("R2", "loaded word", 64'(status), 64'(SW'(m) << 30));
        end

        // R6 R7 R8: compare vector table, quiet, invalid trap disabled
        do_load('0);
        for (int i = 0; i < 12; i++) begin
            logic [1:0] sel;
            sel = 2'(i % 4);
            do_cmp(VEC[i][65:34], VEC[i][33:2], 1'b0, sel);
            check("R6", $sformatf("vector %0d field", i), 64'(status[fld_pos(sel) +: 2]), 64'(VEC[i][1:0]));
            check("R8", $sformatf("vector %0d no trap", i), 64'(trap), 64'h0);
        end
        check("R8", "accrued invalid set", 64'(status[9]), 64'h1);
        check("R8", "current invalid clear", 64'(status[4]), 64'h0);
        check("R8", "trap type unchanged", 64'(status[16:14]), 64'h0);

        // R6: other fields retained
        exp = '0;
        exp[11:10] = 2'b11; exp[33:32] = 2'b11; exp[35:34] = 2'b11; exp[37:36] = 2'b11;
        do_load(exp);
        do_cmp(32'h3F800000, 32'h3F800000, 1'b0, 2'd1);
        exp[33:32] = 2'b00;
        check("R6", "only field 1 rewritten", 64'(status), 64'(exp));

        // R3 R5: flags without enables, accumulation
        do_load('0);
        do_flags(5'b00101);
        check("R3", "current bits", 64'(status[4:0]), 64'h05);
        check("R5", "accrued bits", 64'(status[9:5]), 64'h05);
        check("R5", "no trap", 64'(trap), 64'h0);
        do_flags(5'b10000);
        check("R3", "current replaced", 64'(status[4:0]), 64'h10);
        check("R5", "accrued accumulated", 64'(status[9:5]), 64'h15);

        // R5: enable present but not matching
        do_load(SW'(1) << 23);
        do_flags(5'b00100);
        check("R5", "unmatched enable no trap", 64'(trap), 64'h0);
        check("R5", "unmatched enable accrues", 64'(status[9:5]), 64'h04);

        // R4 R12: enabled overflow traps
        do_load(SW'(1) << 26);
        do_flags(5'b01000);
        check("R4", "trap raised", 64'(trap), 64'h1);
        check("R4", "trap type", 64'(status[16:14]), 64'h1);
        check("R4", "accrued unchanged", 64'(status[9:5]), 64'h0);
        check("R3", "current overflow", 64'(status[4:0]), 64'h08);
        @(negedge clk);
        check("R12", "trap one cycle", 64'(trap), 64'h0);

        // R9: signaling unordered
        do_load('0);
        do_cmp(32'h7FC00000, 32'h00000000, 1'b1, 2'd2);
        check("R9", "signaling trap", 64'(trap), 64'h1);
        check("R9", "current invalid", 64'(status[4]), 64'h1);
        check("R9", "trap type", 64'(status[16:14]), 64'h1);
        check("R6", "unordered field 2", 64'(status[35:34]), 64'h3);
        @(negedge clk);
        check("R12", "trap drops", 64'(trap), 64'h0);

        // R9: quiet unordered with invalid enable
        do_load(SW'(1) << 27);
        do_cmp(32'h3F800000, 32'hFFC00001, 1'b0, 2'd3);
        check("R9", "enabled quiet trap", 64'(trap), 64'h1);
        check("R9", "current invalid", 64'(status[4]), 64'h1);
        check("R8", "accrued untouched", 64'(status[9]), 64'h0);

        // R9: signaling ordered compare does not trap
        do_load('0);
        do_cmp(32'h3F800000, 32'h40000000, 1'b1, 2'd0);
        check("R9", "signaling ordered no trap", 64'(trap), 64'h0);

        // R11: flag beats compare
        do_load('0);
        @(negedge clk);
        flag_valid = 1; flags = 5'b00001;
        cmp_valid = 1; cmp_sel = 2'd0; op_a = 32'h3F800000; op_b = 32'h40000000;
        step();
        check("R11", "compare ignored", 64'(status[11:10]), 64'h0);
        check("R11", "flags applied", 64'(status[4:0]), 64'h01);

        // R2: load beats flags and compare
        @(negedge clk);
        ld_valid = 1; ld_data = SW'(38'h0000000123);
        flag_valid = 1; flags = 5'b11111;
        cmp_valid = 1; op_a = 32'h7FC00000; cmp_signal = 1;
        step();
        check("R2", "load priority", 64'(status), 64'h123);
        check("R2", "no trap with load", 64'(trap), 64'h0);

        // R1: reset clears a populated word
        do_load({SW{1'b1}});
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1", "reset clears", 64'(status), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule